// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage and guesses, in the same cycle as the fetch address is presented, whether the instruction there is a taken branch and where it goes. It has two tables, both indexed by low-order bits of the fetch PC. The direction table has no tag, so two branches that share an index also share a prediction. That costs accuracy but never correctness. The target table keeps a valid bit, a partial PC tag and a full target for each entry. Fetch is redirected only when the direction says taken and the target entry is valid with a matching tag. In every other case fetch carries on at PC+4.

When a branch resolves later in the pipeline, the pipeline sends back the outcome, the actual target and the prediction that was followed at fetch. The block then flags a mispredict and supplies the restart address that the flush and refetch logic uses. Tables are written on the clock edge that ends the update cycle. A lookup in that same cycle therefore still sees the old contents.

A parameter selects the direction state. In the one-bit variant each entry holds the last outcome and is inverted when it was wrong. In the two-bit variant a saturating counter must be wrong twice in a row before its predicted direction flips.

Top module: `fetch_branch_predictor`

## Requirements
- R1: After reset every direction entry predicts not taken and every target entry is invalid, so pred_taken_o is 0 and pred_target_o is lookup_pc_i+4 for any lookup.
- R2: pred_taken_o is 1 only when the direction entry predicts taken and the target entry at the same index is valid with a stored tag equal to lookup_pc_i[IDX_W+2 +: TAG_W]. pred_target_o is then the stored target, and otherwise it is lookup_pc_i+4.
- R3: With TWO_BIT=0 the direction entry is a single bit that is inverted when the resolved outcome differs from it. After an update the entry therefore equals the last outcome.
- R4: With TWO_BIT=1 the entry is a counter 0..3 that predicts taken when its value is 2 or more. A taken outcome adds 1 and saturates at 3. A not-taken outcome subtracts 1 and saturates at 0. The predicted direction flips only after two wrong outcomes in a row.
- R5: Both tables are indexed by lookup_pc_i[IDX_W+1:2], and the direction table has no tag. A PC that differs only above the index shares the direction entry but misses in the target table when its tag differs.
- R6: Every update with upd_taken_i=1 writes valid, tag and upd_target_i into the target entry. A not-taken update leaves the target entry unchanged.
- R7: mispredict_o is 1, in the same cycle as the update, exactly when upd_valid_i is 1 and either upd_taken_i differs from upd_pred_taken_i, or the branch is taken and upd_pred_target_i differs from upd_target_i.
- R8: restart_pc_o is upd_target_i for a taken branch and upd_pc_i+4 for a not-taken one.
- R9: A lookup in the same cycle as an update to the same entry returns the contents held before that update.
- R10: A loop branch that is taken nine times and then not taken, run a second time after one warm-up pass, gives exactly two mispredicts with TWO_BIT=0 and exactly one with TWO_BIT=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | Fetch address being predicted |
| pred_taken_o | output | 1 | Fetch should redirect |
| pred_target_o | output | PC_W | Next fetch address (target or PC+4) |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | PC_W | Resolved taken target |
| upd_pred_taken_i | input | 1 | pred_taken_o that fetch followed for this branch |
| upd_pred_target_i | input | PC_W | pred_target_o that fetch followed for this branch |
| mispredict_o | output | 1 | Flush and restart request |
| restart_pc_o | output | PC_W | Correct-path restart address |

## Verification
On every cycle the assertions check the following. A mispredict never appears without an update. The fall-through restart address is PC+4. A lookup right after a taken update to the same PC hits in the target table. A taken prediction confirmed by a taken outcome stays taken. In one-bit mode the entry follows the last outcome.

Only the bench scenarios can show the rest. These are the loop mispredict counts of each mode, the hysteresis after a single wrong outcome, and aliasing between PCs that share an index. They also cover target replacement, the old-value return on a same-cycle lookup, and the reset state. Each scenario is compared against a model that the bench builds from the requirements.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_e;

  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken && cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
    if (!taken && cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_taken(ctr_e cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bp_dir_table.sv
`timescale 1ns/1ps
module bp_dir_table #(
  parameter int IDX_W   = 6,
  parameter bit TWO_BIT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  import bp_pkg::*;
  localparam int Entries = 1 << IDX_W;

  if (TWO_BIT) begin : g_two_bit
    ctr_e ctr_q [Entries];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < Entries; i++) ctr_q[i] <= CTR_STRONG_NT;
      end else if (wr_en_i) begin
        ctr_q[wr_idx_i] <= ctr_step(ctr_q[wr_idx_i], wr_taken_i);
      end
    end

    assign rd_taken_o = ctr_taken(ctr_q[rd_idx_i]);
  end else begin : g_one_bit
    logic bit_q [Entries];

    // invert only on a wrong guess
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < Entries; i++) bit_q[i] <= 1'b0;
      end else if (wr_en_i && (bit_q[wr_idx_i] != wr_taken_i)) begin
        bit_q[wr_idx_i] <= ~bit_q[wr_idx_i];
      end
    end

    assign rd_taken_o = bit_q[rd_idx_i];
  end
endmodule

// File: rtl/bp_target_buf.sv
`timescale 1ns/1ps
module bp_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] target_o,
  input  logic            wr_en_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [PC_W-1:0] wr_target_i
);
  localparam int Entries = 1 << IDX_W;
  localparam int TagLsb  = IDX_W + 2;

  logic             valid_q  [Entries];
  logic [TAG_W-1:0] tag_q    [Entries];
  logic [PC_W-1:0]  target_q [Entries];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_pc_i[2 +: IDX_W];
  assign wr_idx = wr_pc_i[2 +: IDX_W];
  assign rd_tag = rd_pc_i[TagLsb +: TAG_W];
  assign wr_tag = wr_pc_i[TagLsb +: TAG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Entries; i++) valid_q[i] <= 1'b0;
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // payload needs no reset: guarded by valid
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx]    <= wr_tag;
      target_q[wr_idx] <= wr_target_i;
    end
  end

  assign hit_o    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign target_o = target_q[rd_idx];
endmodule

// File: rtl/bp_resolve.sv
`timescale 1ns/1ps
module bp_resolve #(
  parameter int PC_W = 32
) (
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_pred_taken_i,
  input  logic [PC_W-1:0] upd_pred_target_i,
  output logic            mispredict_o,
  output logic [PC_W-1:0] restart_pc_o
);
  logic dir_wrong, tgt_wrong;

  assign dir_wrong    = upd_taken_i != upd_pred_taken_i;
  assign tgt_wrong    = upd_taken_i && (upd_pred_target_i != upd_target_i);
  assign mispredict_o = upd_valid_i && (dir_wrong || tgt_wrong);
  assign restart_pc_o = upd_taken_i ? upd_target_i : upd_pc_i + PC_W'(4);
endmodule

// File: rtl/fetch_branch_predictor.sv
`timescale 1ns/1ps
module fetch_branch_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 8,
  parameter bit TWO_BIT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_pred_taken_i,
  input  logic [PC_W-1:0] upd_pred_target_i,
  output logic            mispredict_o,
  output logic [PC_W-1:0] restart_pc_o
);
  logic            dir_taken;
  logic            tgt_hit;
  logic [PC_W-1:0] tgt_pc;

  bp_dir_table #(.IDX_W(IDX_W), .TWO_BIT(TWO_BIT)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lookup_pc_i[2 +: IDX_W]),
    .rd_taken_o (dir_taken),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_pc_i[2 +: IDX_W]),
    .wr_taken_i (upd_taken_i)
  );

  bp_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_pc_i     (lookup_pc_i),
    .hit_o       (tgt_hit),
    .target_o    (tgt_pc),
    .wr_en_i     (upd_valid_i && upd_taken_i),
    .wr_pc_i     (upd_pc_i),
    .wr_target_i (upd_target_i)
  );

  bp_resolve #(.PC_W(PC_W)) u_res (
    .upd_valid_i       (upd_valid_i),
    .upd_pc_i          (upd_pc_i),
    .upd_taken_i       (upd_taken_i),
    .upd_target_i      (upd_target_i),
    .upd_pred_taken_i  (upd_pred_taken_i),
    .upd_pred_target_i (upd_pred_target_i),
    .mispredict_o      (mispredict_o),
    .restart_pc_o      (restart_pc_o)
  );

  // redirect needs both a taken guess and a usable target
  assign pred_taken_o  = dir_taken && tgt_hit;
  assign pred_target_o = pred_taken_o ? tgt_pc : lookup_pc_i + PC_W'(4);
endmodule

// File: rtl/bp_checker.sv
`timescale 1ns/1ps
module bp_checker #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter bit TWO_BIT = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lookup_pc_i,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic            mispredict_o,
  input logic [PC_W-1:0] restart_pc_o,
  input logic            dir_taken,
  input logic            tgt_hit
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  assign lk_idx = lookup_pc_i[2 +: IDX_W];
  assign up_idx = upd_pc_i[2 +: IDX_W];

  a_r7_miss_needs_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> upd_valid_i);

  a_r8_fallthrough_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |-> (restart_pc_o == upd_pc_i + PC_W'(4)));

  a_r6_target_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=> ((lookup_pc_i != $past(upd_pc_i)) || tgt_hit));

  a_r4_taken_confirmed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && dir_taken && (lk_idx == up_idx))
      |=> ((lk_idx != $past(up_idx)) || dir_taken));

  if (!TWO_BIT) begin : g_one_bit_chk
    a_r3_follows_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_valid_i |=> ((lk_idx != $past(up_idx)) || (dir_taken == $past(upd_taken_i))));
  end
endmodule

bind fetch_branch_predictor bp_checker #(.PC_W(PC_W), .IDX_W(IDX_W), .TWO_BIT(TWO_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_pc_i  (lookup_pc_i),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i),
  .mispredict_o (mispredict_o),
  .restart_pc_o (restart_pc_o),
  .dir_taken    (dir_taken),
  .tgt_hit      (tgt_hit)
);

// File: tb/fetch_branch_predictor_bench.sv
`timescale 1ns/1ps
module fetch_branch_predictor_bench;
  localparam int PC_W = 32;
  localparam int IDX_W = 6;
  localparam int TAG_W = 8;
  localparam int ENT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [PC_W-1:0] lookup_pc = '0, upd_pc = '0, upd_target = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pt_a = 1'b0, pt_b = 1'b0;
  logic [PC_W-1:0] ptg_a = '0, ptg_b = '0;
  logic p_taken_a, p_taken_b, miss_a, miss_b;
  logic [PC_W-1:0] p_tgt_a, p_tgt_b, rst_pc_a, rst_pc_b;

  // a: two-bit counters, b: one-bit
  fetch_branch_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TWO_BIT(1'b1)) u_fetch_branch_predictor (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lookup_pc),
    .pred_taken_o(p_taken_a), .pred_target_o(p_tgt_a),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_target_i(upd_target), .upd_pred_taken_i(pt_a), .upd_pred_target_i(ptg_a),
    .mispredict_o(miss_a), .restart_pc_o(rst_pc_a));

  fetch_branch_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TWO_BIT(1'b0)) u_fetch_branch_predictor_1b (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lookup_pc),
    .pred_taken_o(p_taken_b), .pred_target_o(p_tgt_b),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_target_i(upd_target), .upd_pred_taken_i(pt_b), .upd_pred_target_i(ptg_b),
    .mispredict_o(miss_b), .restart_pc_o(rst_pc_b));

  typedef enum int {K_PT_A, K_TG_A, K_MS_A, K_RS_A, K_PT_B, K_TG_B, K_MS_B, K_RS_B} kind_e;
  typedef struct {string tag; kind_e kind; logic [PC_W-1:0] exp;} item_t;
  item_t exp_q[$];
  event sample_ev;
  int n_checks = 0, n_fail = 0;

  // reference state built from the requirements
  int          m_ctr [ENT];
  logic        m_bit [ENT];
  logic        m_v   [ENT];
  logic [TAG_W-1:0] m_tag [ENT];
  logic [PC_W-1:0]  m_tgt [ENT];
  int miss_cnt_a = 0, miss_cnt_b = 0;

  function automatic int ix(logic [PC_W-1:0] pc); return int'(pc[2 +: IDX_W]); endfunction
  function automatic logic [TAG_W-1:0] tg(logic [PC_W-1:0] pc); return pc[IDX_W+2 +: TAG_W]; endfunction

  function automatic logic m_pred(bit two, logic [PC_W-1:0] pc);
    logic d;
    d = two ? (m_ctr[ix(pc)] >= 2) : m_bit[ix(pc)];
    return d && m_v[ix(pc)] && (m_tag[ix(pc)] == tg(pc));
  endfunction

  function automatic logic [PC_W-1:0] m_next(bit two, logic [PC_W-1:0] pc);
    return m_pred(two, pc) ? m_tgt[ix(pc)] : pc + 32'd4;
  endfunction

  always @(sample_ev) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [PC_W-1:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        K_PT_A: act = {31'd0, p_taken_a};
        K_TG_A: act = p_tgt_a;
        K_MS_A: act = {31'd0, miss_a};
        K_RS_A: act = rst_pc_a;
        K_PT_B: act = {31'd0, p_taken_b};
        K_TG_B: act = p_tgt_b;
        K_MS_B: act = {31'd0, miss_b};
        default: act = rst_pc_b;
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%s actual=%h expected=%h", it.tag, it.kind.name(), act, it.exp);
      end
    end
  end

  task automatic push(string tag, kind_e k, logic [PC_W-1:0] v);
    item_t it;
    it.tag = tag; it.kind = k; it.exp = v;
    exp_q.push_back(it);
  endtask

  task automatic push_preds(string tag, logic [PC_W-1:0] pc);
    push(tag, K_PT_A, {31'd0, m_pred(1'b1, pc)});
    push(tag, K_TG_A, m_next(1'b1, pc));
    push(tag, K_PT_B, {31'd0, m_pred(1'b0, pc)});
    push(tag, K_TG_B, m_next(1'b0, pc));
  endtask

  // one branch: lookup cycle, then resolve cycle with same-cycle lookup
  task automatic branch(string tag, logic [PC_W-1:0] pc, logic taken, logic [PC_W-1:0] tgt);
    logic pa, pb;
    logic [PC_W-1:0] na, nb, rs;
    @(negedge clk);
    upd_valid = 1'b0;
    lookup_pc = pc;
    #1;
    push_preds(tag, pc);
    -> sample_ev;
    pa = m_pred(1'b1, pc); na = m_next(1'b1, pc);
    pb = m_pred(1'b0, pc); nb = m_next(1'b0, pc);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = taken; upd_target = tgt;
    pt_a = pa; ptg_a = na; pt_b = pb; ptg_b = nb;
    #1;
    push_preds("R9", pc);  // tables not yet written
    rs = taken ? tgt : pc + 32'd4;
    push("R7", K_MS_A, {31'd0, (taken != pa) || (taken && na != tgt)});
    push("R7", K_MS_B, {31'd0, (taken != pb) || (taken && nb != tgt)});
    push("R8", K_RS_A, rs);
    push("R8", K_RS_B, rs);
    -> sample_ev;
    if (miss_a) miss_cnt_a++;
    if (miss_b) miss_cnt_b++;
    // model update for the coming edge
    m_bit[ix(pc)] = taken;
    if (taken && m_ctr[ix(pc)] < 3) m_ctr[ix(pc)]++;
    if (!taken && m_ctr[ix(pc)] > 0) m_ctr[ix(pc)]--;
    if (taken) begin
      m_v[ix(pc)] = 1'b1; m_tag[ix(pc)] = tg(pc); m_tgt[ix(pc)] = tgt;
    end
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic check_count(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s mispredict count actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_loop(logic [PC_W-1:0] pc, logic [PC_W-1:0] top);
    for (int k = 0; k < 10; k++) branch("R10", pc, (k < 9), top);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] loop_pc, alias_pc, lfsr;
    for (int i = 0; i < ENT; i++) begin
      m_ctr[i] = 0; m_bit[i] = 1'b0; m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    loop_pc  = 32'h0000_1240;
    alias_pc = loop_pc + 32'h0000_0100;  // same index, other tag
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing predicted after reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lookup_pc = 32'h0000_2000 + 32'(i * 52);
      #1;
      push_preds("R1", lookup_pc);
      -> sample_ev;
    end

    // R10 warm-up pass: R4 needs two wrong before flipping, R3 one
    miss_cnt_a = 0; miss_cnt_b = 0;
    run_loop(loop_pc, 32'h0000_1000);
    check_count("R4 warm-up two-bit", miss_cnt_a, 3);
    check_count("R3 warm-up one-bit", miss_cnt_b, 2);
    miss_cnt_a = 0; miss_cnt_b = 0;
    run_loop(loop_pc, 32'h0000_1000);
    check_count("R10 two-bit", miss_cnt_a, 1);
    check_count("R10 one-bit", miss_cnt_b, 2);

    // R4 hysteresis: one not-taken leaves two-bit still taken
    branch("R4", loop_pc, 1'b1, 32'h0000_1000);

    // R5 alias: shares direction entry, misses on tag
    branch("R5", alias_pc, 1'b0, 32'h0000_3000);
    branch("R5", loop_pc, 1'b1, 32'h0000_1000);
    // R6 not-taken alias did not disturb target entry; taken alias replaces it
    branch("R6", alias_pc, 1'b1, 32'h0000_3000);
    branch("R6", loop_pc, 1'b1, 32'h0000_1000);
    // R7 target change on a correctly predicted taken branch
    branch("R7", loop_pc, 1'b1, 32'h0000_1800);
    branch("R7", loop_pc, 1'b1, 32'h0000_1800);

    // R2 mixed traffic over several PCs
    lfsr = 32'hACE1_0001;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      branch("R2", {20'h0, 2'b00, lfsr[3:0], 2'b00, 4'h0} + 32'h0000_4000,
             lfsr[7] | lfsr[9], {16'h0, lfsr[15:4], 4'h0});
    end

    @(negedge clk);
    finish_run();
  end
endmodule